// File: doc/BRIEF.md
# Programmable Serial CRC Engine

This block computes a cyclic redundancy check over a serial bit stream, one bit per accepted clock edge, using a shift register whose feedback taps come from a programmable polynomial register. The width is set by a parameter in whole bytes, so the same block covers 8-bit, 16-bit and longer checks. The polynomial is stored with its constant term left out. Register bit `k` selects the term x^(k+1), so a W-bit check needs only W stored bits.

Software uses an 8-bit register bus. It writes the polynomial, and it writes a starting value through the seed/result register while the engine is stopped. It then sets the enable bit and streams bits in through a valid/ready input. To collect the result, it clears the enable bit and reads each byte in two steps. The first read goes to the shift-register address and returns zero while capturing that byte. The second read goes to the seed/result address and returns the captured byte. While enabled, the engine shows the shift-register MSB on a serial output. It also raises a one-cycle interrupt when a step leaves the shift register equal to the seed/result register.

Top module: `crc_engine`

## Requirements
- R1: The polynomial register holds bits for x^W down to x^1 in register bits W-1..0. The x^0 term is implied. The 16-bit polynomial x^16+x^12+x^5+1 is written as 0x8810: lane 1 takes 0x88 and lane 0 takes 0x10. Each lane reads back what was written.
- R2: `bus_sel` selects a register: 0 is control (bit 0 is enable, and it reads back as {7'b0, enable}), 1 is the shift register, 2 is the polynomial and 3 is seed/result. `bus_lane` selects the byte, where lane 0 is bits 7..0. A write takes effect at the next rising edge. Read data appears on `bus_rdata` one cycle after `bus_rd` and is 0 in any cycle that follows no read.
- R3: While the block is disabled, `din_ready`, `sout` and `irq` are all 0, and `din_valid` has no effect on the shift register. After reset the block is disabled and every register is 0.
- R4: A write to seed/result while the block is disabled loads that byte into both the seed register and the shift register. While the block is enabled, the same write changes only the seed register.
- R5: On an edge where `din_valid && din_ready`, let L be the shift register and fb = L[W-1] ^ `din_bit`. The next value is (L << 1) ^ (fb ? {poly[W-2:0], 1'b1} : 0). On any other edge the shift register holds.
- R6: While the block is enabled, `sout` equals the shift-register MSB.
- R7: A read of the shift-register address returns 0. If the block is disabled, that read also captures the addressed byte into a shadow. A read of seed/result returns the shadow byte for that lane and then clears it. A capture attempted while the block is enabled leaves the shadow unchanged.
- R8: `irq` is high for exactly the one cycle that follows a step whose new shift-register value equals the seed register. It is low otherwise.
- R9: `din_ready` equals the enable bit. A bit is consumed only on an edge with valid and ready both high, and a held `din_valid` waits without loss.
- R10: Writes to the shift-register address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select |
| bus_lane | input | LANE_W | Byte lane select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| din_valid | input | 1 | Serial bit offered |
| din_ready | output | 1 | Engine accepts bits (enabled) |
| din_bit | input | 1 | Serial data bit |
| sout | output | 1 | Shift-register MSB while enabled |
| irq | output | 1 | One-cycle compare pulse |

## Verification
The assertions assume that `bus_lane` always names an existing byte lane. They also assume that `din_bit` is a known value whenever `din_valid` is high. The bench only ever uses lanes 0 and 1 with the default width, and it drives a defined bit alongside every valid. Register accesses and stream bits go in separate cycles, so a seed write never coincides with a step. The one exception is a held `din_valid` while the block is disabled, which exercises the ignore rule.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LFSR = 2'd1,
    REG_POLY = 2'd2,
    REG_SEED = 2'd3
  } crc_reg_e;
endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
  parameter int W      = 16,
  parameter int LANE_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              din_bit,
  input  logic [W-2:0]      taps,
  input  logic              load,
  input  logic [LANE_W-1:0] load_lane,
  input  logic [7:0]        load_byte,
  output logic [W-1:0]      state,
  output logic [W-1:0]      state_nxt
);
  logic fb;

  always_comb begin
    fb        = state[W-1] ^ din_bit;
    state_nxt = {state[W-2:0], 1'b0};
    if (fb) state_nxt = state_nxt ^ {taps, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= '0;
    else if (load) state[int'(load_lane)*8 +: 8] <= load_byte;
    else if (step) state <= state_nxt;
  end
endmodule

// File: rtl/crc_readback.sv
module crc_readback import crc_pkg::*; #(
  parameter int BYTES  = 2,
  parameter int W      = 8*BYTES,
  parameter int LANE_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [1:0]        sel,
  input  logic [LANE_W-1:0] lane,
  input  logic              en,
  input  logic [W-1:0]      lfsr,
  input  logic [W-1:0]      poly,
  output logic [7:0]        rdata
);
  logic [7:0] shadow [BYTES];
  logic [7:0] rd_byte;

  for (genvar g = 0; g < BYTES; g++) begin : g_shadow
    logic hit;
    assign hit = rd && (lane == LANE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          shadow[g] <= '0;
      else if (hit && sel == REG_LFSR && !en) shadow[g] <= lfsr[g*8 +: 8];
      else if (hit && sel == REG_SEED)     shadow[g] <= '0;
    end
  end

  always_comb begin
    rd_byte = '0;
    case (sel)
      REG_CTRL: rd_byte = {7'b0, en};
      REG_LFSR: rd_byte = '0;
      REG_POLY: rd_byte = poly[int'(lane)*8 +: 8];
      REG_SEED: rd_byte = shadow[lane];
      default:  rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_byte;
    else         rdata <= '0;
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine import crc_pkg::*; #(
  parameter  int BYTES  = 2,
  localparam int W      = BYTE_W*BYTES,
  localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic [LANE_W-1:0] bus_lane,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic              din_bit,
  output logic              sout,
  output logic              irq
);
  logic         en_q;
  logic [W-1:0] poly_q;
  logic [W-1:0] seed_q;
  logic [W-1:0] lfsr_q;
  logic [W-1:0] lfsr_nxt;
  logic         irq_q;
  logic         step;
  logic         seed_wr;

  assign step      = din_valid && en_q;
  assign seed_wr   = bus_wr && (bus_sel == REG_SEED);
  assign din_ready = en_q;
  assign sout      = en_q & lfsr_q[W-1];
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              en_q <= 1'b0;
    else if (bus_wr && bus_sel == REG_CTRL)  en_q <= bus_wdata[0];
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic lane_hit;
    assign lane_hit = bus_wr && (bus_lane == LANE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        poly_q[g*8 +: 8] <= '0;
        seed_q[g*8 +: 8] <= '0;
      end else begin
        if (lane_hit && bus_sel == REG_POLY) poly_q[g*8 +: 8] <= bus_wdata;
        if (lane_hit && bus_sel == REG_SEED) seed_q[g*8 +: 8] <= bus_wdata;
      end
    end
  end

  crc_lfsr #(.W(W), .LANE_W(LANE_W)) u_lfsr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .din_bit   (din_bit),
    .taps      (poly_q[W-2:0]),
    .load      (seed_wr && !en_q),
    .load_lane (bus_lane),
    .load_byte (bus_wdata),
    .state     (lfsr_q),
    .state_nxt (lfsr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= step && (lfsr_nxt == seed_q);
  end

  crc_readback #(.BYTES(BYTES), .W(W), .LANE_W(LANE_W)) u_rb (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (bus_rd),
    .sel   (bus_sel),
    .lane  (bus_lane),
    .en    (en_q),
    .lfsr  (lfsr_q),
    .poly  (poly_q),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
  parameter int W      = 16,
  parameter int LANE_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_sel,
  input logic [LANE_W-1:0] bus_lane,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              din_valid,
  input logic              din_ready,
  input logic              sout,
  input logic              irq,
  input logic              en_q,
  input logic [W-1:0]      lfsr_q,
  input logic [W-1:0]      seed_q
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!din_ready && !sout && !irq)); // R3

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd3 && !en_q) |=>
      lfsr_q[int'($past(bus_lane))*8 +: 8] == $past(bus_wdata)); // R4

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!(din_valid && din_ready) && !(bus_wr && bus_sel == 2'd3 && !en_q)) |=> $stable(lfsr_q)); // R5

  AST_LFSR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == 2'd1) |=> bus_rdata == 8'h00); // R7

  AST_IRQ_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(din_valid && din_ready)); // R8

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> lfsr_q == $past(seed_q)); // R8
endmodule

bind crc_engine crc_engine_chk #(.W(W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_sel   (bus_sel),
  .bus_lane  (bus_lane),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .din_valid (din_valid),
  .din_ready (din_ready),
  .sout      (sout),
  .irq       (irq),
  .en_q      (en_q),
  .lfsr_q    (lfsr_q),
  .seed_q    (seed_q)
);

// File: tb/tb_crc_engine.sv
module tb_crc_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [0:0] bus_lane = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       din_valid = 1'b0, din_bit = 1'b0;
  logic       din_ready, sout, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] m_crc = 16'h0, m_seed = 16'h0, m_poly = 16'h0;
  logic        m_en = 1'b0;
  logic [7:0]  m_shadow [2] = '{8'h00, 8'h00};
  int          irq_seen = 0;
  logic        last_irq_exp = 1'b0;

  always #4 clk = ~clk;

  crc_engine #(.BYTES(2)) dut (.*);

  function automatic logic [15:0] ref_bit(logic [15:0] c, logic b);
    logic f;
    f = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic tick(string rtag);
    logic       irq_e, en_old;
    logic [7:0] rd_e;
    @(posedge clk);
    irq_e = 1'b0; rd_e = 8'h00; en_old = m_en;
    if (din_valid && m_en) begin
      m_crc = ref_bit(m_crc, din_bit);
      irq_e = (m_crc == m_seed);
    end
    if (bus_rd) begin
      case (bus_sel)
        2'd0: rd_e = {7'b0, m_en};
        2'd1: begin rd_e = 8'h00; if (!m_en) m_shadow[bus_lane] = m_crc[bus_lane*8 +: 8]; end
        2'd2: rd_e = m_poly[bus_lane*8 +: 8];
        default: begin rd_e = m_shadow[bus_lane]; m_shadow[bus_lane] = 8'h00; end
      endcase
    end
    if (bus_wr) begin
      case (bus_sel)
        2'd0: m_en = bus_wdata[0];
        2'd2: m_poly[bus_lane*8 +: 8] = bus_wdata;
        2'd3: begin
          m_seed[bus_lane*8 +: 8] = bus_wdata;
          if (!en_old) m_crc[bus_lane*8 +: 8] = bus_wdata;
        end
        default: ;
      endcase
    end
    #1;
    chk("R9 din_ready", din_ready, m_en);
    chk("R6 sout", sout, m_en ? m_crc[15] : 1'b0);
    chk("R8 irq", irq, irq_e);
    chk(rtag, bus_rdata, rd_e);
    last_irq_exp = irq_e;
    if (irq) irq_seen++;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; din_valid = 0;
  endtask

  task automatic wr(logic [1:0] s, logic l, logic [7:0] d);
    bus_wr = 1; bus_sel = s; bus_lane = l; bus_wdata = d;
    tick("R2 rdata");
  endtask

  task automatic rd(logic [1:0] s, logic l, string rtag);
    bus_rd = 1; bus_sel = s; bus_lane = l;
    tick(rtag);
  endtask

  task automatic push_byte(logic [7:0] b, bit gaps);
    for (int i = 7; i >= 0; i--) begin
      din_valid = 1; din_bit = b[i];
      tick("R5 step");
      if (gaps && i[0]) tick("R9 idle hold");
    end
  endtask

  task automatic read_result(string rtag);
    for (int l = 1; l >= 0; l--) begin
      rd(2'd1, l[0], "R7 lfsr read zero");
      rd(2'd3, l[0], rtag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset din_ready", din_ready, 0);
    chk("R3 reset sout", sout, 0);
    chk("R3 reset irq", irq, 0);
    chk("R3 reset rdata", bus_rdata, 0);
    rd(2'd0, 0, "R2 ctrl reset");
    rd(2'd3, 0, "R3 seed reset");

    // R1: CCITT polynomial, two lanes
    wr(2'd2, 1, 8'h88);
    wr(2'd2, 0, 8'h10);
    rd(2'd2, 1, "R1 poly lane1");
    rd(2'd2, 0, "R1 poly lane0");
    chk("R1 poly value", m_poly, 16'h8810);

    // R3: held valid while disabled is ignored
    din_valid = 1; din_bit = 1; tick("R3 disabled ignore");
    din_valid = 1; din_bit = 1; tick("R3 disabled ignore");
    read_result("R3 lfsr untouched");

    // seed 0, random stream
    for (int pass = 0; pass < 2; pass++) begin
      logic [7:0] s;
      s = pass == 0 ? 8'h00 : 8'hFF;
      wr(2'd3, 1, s); wr(2'd3, 0, s);
      wr(2'd0, 0, 8'h01);
      rd(2'd0, 0, "R2 ctrl enabled");
      for (int k = 0; k < 6; k++) push_byte(8'($urandom), k[0]);
      wr(2'd0, 0, 8'h00);
      read_result(pass == 0 ? "R7 result seed0" : "R7 result seedFF");
      rd(2'd3, 0, "R7 shadow cleared");
    end

    // R8: message followed by its CRC drives the register to 0 = seed
    wr(2'd3, 1, 8'h00); wr(2'd3, 0, 8'h00);
    wr(2'd0, 0, 8'h01);
    push_byte(8'hA5, 0); push_byte(8'h3C, 0);
    c = m_crc;
    irq_seen = 0;
    push_byte(c[15:8], 0);
    push_byte(c[7:0], 0);
    chk("R8 irq on final match", irq, 1);
    chk("R8 expected match", last_irq_exp, 1);
    din_valid = 0; tick("R8 idle");
    chk("R8 one cycle", irq, 0);

    // R4: seed write while enabled does not load; R10: lfsr write ignored
    push_byte(8'h5A, 1);
    wr(2'd3, 0, 8'hC3);
    wr(2'd1, 0, 8'h77);
    wr(2'd1, 1, 8'h77);
    push_byte(8'h81, 0);
    // R7: capture while enabled leaves shadow zero
    rd(2'd1, 0, "R7 lfsr read zero enabled");
    rd(2'd3, 0, "R7 no capture when enabled");
    wr(2'd0, 0, 8'h00);
    read_result("R4 R10 result");

    // R4: disabled seed write loads lfsr
    wr(2'd3, 0, 8'h3E); wr(2'd3, 1, 8'h9D);
    read_result("R4 seed loaded");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule